// File: doc/BRIEF.md
# Receive-Path Address Translation Cache

This block turns the virtual address of an incoming remote write into a physical address before the write is placed in memory. It keeps a small, fully associative table of page translations. A lookup that finds its page in the table is answered in hardware one cycle after it is accepted, and the embedded control processor plays no part in it.

When a lookup misses, the block raises a request toward a slow-path interface that stands in for that processor. The request carries the virtual page number. The block stops accepting input until the slow path returns the physical page. The returned translation is written into the table and the stalled request is then answered.

Software can write a translation directly, remove one translation by its virtual page, or empty the whole table in a single cycle. Two counters report how many accepted lookups hit and how many missed.

Top module: `rx_xlate_cache`

## Requirements
- R1: After reset, reqReady is 1, rspValid and missReq are 0, both counters are 0, and every table entry is invalid.
- R2: The virtual page is reqVaddr[47:12] and the offset is reqVaddr[11:0]. rspPaddr[39:12] carries the physical page and rspPaddr[11:0] carries the offset unchanged.
- R3: An accepted lookup (reqValid and reqReady) that hits sets rspValid for one cycle on the next clock, does not raise missReq, and adds 1 to hitCount.
- R4: An accepted lookup that misses raises missReq on the next clock with missVpn set to its virtual page. It drops reqReady and adds 1 to missCount.
- R5: missReq, missVpn and the low reqReady hold until fillValid. On the clock that samples fillValid, the translation is installed, missReq falls, reqReady rises, and rspValid is set with {fillPpn, held offset}.
- R6: The slot for an install is chosen in this order: the entry already holding that virtual page is overwritten; otherwise the lowest-index invalid entry is used; otherwise the entry at a round-robin pointer is used. The pointer starts at 0 after reset and advances, wrapping, only when it chooses the slot.
- R7: A software insert (swInsValid) installs a translation that later lookups hit. If it arrives in the same cycle as a refill, the refill is installed and the insert is dropped.
- R8: swInvAll makes every entry invalid in one cycle, and no install takes effect in that cycle.
- R9: swInvOne invalidates only the entry whose virtual page equals swInvVpn. Other entries still hit.
- R10: A lookup accepted in the same cycle as a table change is answered from the table contents as they were before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block can accept a lookup |
| reqVaddr | input | 48 | Virtual address to translate |
| rspValid | output | 1 | Translation result valid (one-cycle pulse) |
| rspPaddr | output | 40 | Translated physical address |
| missReq | output | 1 | Slow-path refill request pending |
| missVpn | output | 36 | Virtual page to be resolved by the slow path |
| fillValid | input | 1 | Slow path returns the translation |
| fillPpn | input | 28 | Physical page returned by the slow path |
| swInsValid | input | 1 | Software insert strobe |
| swInsVpn | input | 36 | Virtual page to insert |
| swInsPpn | input | 28 | Physical page to insert |
| swInvOne | input | 1 | Invalidate the entry matching swInvVpn |
| swInvVpn | input | 36 | Virtual page to invalidate |
| swInvAll | input | 1 | Invalidate every entry |
| hitCount | output | 32 | Number of accepted lookups that hit |
| missCount | output | 32 | Number of accepted lookups that missed |

## Verification
The assertions assume three things about the environment. The table never holds two valid entries for the same virtual page. fillValid is only given while missReq is high. The request address is not sampled while reqReady is low.

The stimulus stays within these limits. Every insert passes through the overwrite-by-match rule, so a page never appears twice. The fill pulse is driven only after missReq has been seen. Lookups are issued only while the block is idle.

Same-cycle overlaps are driven on purpose: an invalidate together with a lookup, and a software insert together with a refill. This lets the priority between table updates and the lookup be observed at the ports.

// File: rtl/rx_xlate_pkg.sv
package rx_xlate_pkg;

  // Strobes from the control FSM to the datapath, one per table or output action.
  typedef struct packed {
    logic acceptHit;   // lookup accepted and hit
    logic acceptMiss;  // lookup accepted and missed
    logic fill;        // slow-path refill arriving
    logic swIns;       // software insert (already masked by refill)
    logic invOne;      // single-entry invalidate
    logic invAll;      // invalidate everything
  } ctrlStrobes_t;

endpackage

// File: rtl/rx_xlate_pick.sv
// Lowest-index set bit finder.
module rx_xlate_pick #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rx_xlate_ctrl.sv
module rx_xlate_ctrl
  import rx_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         lookupHit,
  input  logic         fillValid,
  input  logic         swInsValid,
  input  logic         swInvOne,
  input  logic         swInvAll,
  output logic         reqReady,
  output logic         missReq,
  output ctrlStrobes_t strb
);
  logic busyQ;

  always_comb begin
    strb.acceptHit  = reqValid && !busyQ && lookupHit;
    strb.acceptMiss = reqValid && !busyQ && !lookupHit;
    strb.fill       = busyQ && fillValid;
    strb.swIns      = swInsValid && !(busyQ && fillValid);
    strb.invOne     = swInvOne;
    strb.invAll     = swInvAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           busyQ <= 1'b0;
    else if (busyQ)      busyQ <= !fillValid;
    else if (reqValid)   busyQ <= !lookupHit;
  end

  assign reqReady = !busyQ;
  assign missReq  = busyQ;

  // R4: a missing accepted lookup raises the slow-path request
  a_r4_miss_raises: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lookupHit) |=> missReq);
  // R3: a hit never involves the slow path
  a_r3_hit_no_slow: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lookupHit) |=> !missReq);
  // R5: request held until the slow path answers
  a_r5_hold_miss: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && !fillValid) |=> missReq);
  // R5: an answer releases the stall
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && fillValid) |=> (!missReq && reqReady));
endmodule

// File: rtl/rx_xlate_datapath.sv
module rx_xlate_datapath
  import rx_xlate_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 48,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 12,
  parameter int CNT_W     = 32,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [VPN_W-1:0]  swInsVpn,
  input  logic [PPN_W-1:0]  swInsPpn,
  input  logic [VPN_W-1:0]  swInvVpn,
  output logic              lookupHit,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [VPN_W-1:0]  missVpn,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PPN_W-1:0]   ppnQ [ENTRIES];
  logic [IDX_W-1:0]   rrQ;
  logic [VA_W-1:0]    heldVaddr;

  logic [VPN_W-1:0]   reqVpn, insVpn;
  logic [PPN_W-1:0]   insPpn;
  logic [ENTRIES-1:0] lkMatch, insMatch, invMatch;
  logic [IDX_W-1:0]   hitIdx, insIdx, freeIdx, tgtIdx;
  logic               insAny, freeAny, doInstall, useRr;

  assign reqVpn = reqVaddr[VA_W-1:PAGE_BITS];
  assign insVpn = strb.fill ? heldVaddr[VA_W-1:PAGE_BITS] : swInsVpn;
  assign insPpn = strb.fill ? fillPpn : swInsPpn;

  // three compare ports: lookup, install, invalidate
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkMatch[g]  = validQ[g] && (vpnQ[g] == reqVpn);
    assign insMatch[g] = validQ[g] && (vpnQ[g] == insVpn);
    assign invMatch[g] = validQ[g] && (vpnQ[g] == swInvVpn);
  end

  rx_xlate_pick #(.N(ENTRIES)) u_pickHit  (.vec(lkMatch),  .any(lookupHit), .idx(hitIdx));
  rx_xlate_pick #(.N(ENTRIES)) u_pickIns  (.vec(insMatch), .any(insAny),    .idx(insIdx));
  rx_xlate_pick #(.N(ENTRIES)) u_pickFree (.vec(~validQ),  .any(freeAny),   .idx(freeIdx));

  always_comb begin
    doInstall = (strb.fill || strb.swIns) && !strb.invAll;
    useRr     = !insAny && !freeAny;
    if (insAny)       tgtIdx = insIdx;
    else if (freeAny) tgtIdx = freeIdx;
    else              tgtIdx = rrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ    <= '0;
      rrQ       <= '0;
      heldVaddr <= '0;
      rspValid  <= 1'b0;
      rspPaddr  <= '0;
      hitCount  <= '0;
      missCount <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        ppnQ[i] <= '0;
      end
    end else begin
      rspValid <= strb.acceptHit || strb.fill;
      if (strb.acceptHit)
        rspPaddr <= {ppnQ[hitIdx], reqVaddr[PAGE_BITS-1:0]};
      else if (strb.fill)
        rspPaddr <= {fillPpn, heldVaddr[PAGE_BITS-1:0]};
      if (strb.acceptMiss) heldVaddr <= reqVaddr;
      if (strb.acceptHit)  hitCount  <= hitCount + 1'b1;
      if (strb.acceptMiss) missCount <= missCount + 1'b1;

      if (strb.invAll) begin
        validQ <= '0;
      end else begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (strb.invOne && invMatch[i]) validQ[i] <= 1'b0;
        end
        if (doInstall) begin
          validQ[tgtIdx] <= 1'b1;
          vpnQ[tgtIdx]   <= insVpn;
          ppnQ[tgtIdx]   <= insPpn;
          if (useRr) rrQ <= (rrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrQ + 1'b1;
        end
      end
    end
  end

  assign missVpn = heldVaddr[VA_W-1:PAGE_BITS];

  // R6: placement keeps tags unique, so a lookup matches at most one entry
  a_r6_unique_tag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));
  // R8: a global invalidate leaves nothing valid
  a_r8_all_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.invAll |=> (validQ == '0));
  // R2: offset passes through on a hit
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    strb.acceptHit |=> (rspPaddr[PAGE_BITS-1:0] == $past(reqVaddr[PAGE_BITS-1:0])));
  // R3: hit counter advances by exactly one per hit
  a_r3_hit_count: assert property (@(posedge clk) disable iff (!rstN)
    strb.acceptHit |=> (hitCount == $past(hitCount) + 1'b1));
  // R9: single invalidate removes the matching entry
  a_r9_inv_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.invOne && !doInstall && lookupHit && (reqVpn == swInvVpn)) |=> !validQ[$past(hitIdx)]);
endmodule

// File: rtl/rx_xlate_cache.sv
module rx_xlate_cache
  import rx_xlate_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 48,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 12,
  parameter int CNT_W     = 32,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             missReq,
  output logic [VPN_W-1:0] missVpn,
  input  logic             fillValid,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             swInsValid,
  input  logic [VPN_W-1:0] swInsVpn,
  input  logic [PPN_W-1:0] swInsPpn,
  input  logic             swInvOne,
  input  logic [VPN_W-1:0] swInvVpn,
  input  logic             swInvAll,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  ctrlStrobes_t strb;
  logic         lookupHit;

  rx_xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lookupHit(lookupHit),
    .fillValid(fillValid), .swInsValid(swInsValid), .swInvOne(swInvOne),
    .swInvAll(swInvAll), .reqReady(reqReady), .missReq(missReq), .strb(strb)
  );

  rx_xlate_datapath #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
    .PAGE_BITS(PAGE_BITS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqVaddr(reqVaddr),
    .fillPpn(fillPpn), .swInsVpn(swInsVpn), .swInsPpn(swInsPpn),
    .swInvVpn(swInvVpn), .lookupHit(lookupHit), .rspValid(rspValid),
    .rspPaddr(rspPaddr), .missVpn(missVpn), .hitCount(hitCount),
    .missCount(missCount)
  );
endmodule

// File: tb/rx_xlate_cache_bench.sv
module rx_xlate_cache_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        reqValid = 0, fillValid = 0, swInsValid = 0, swInvOne = 0, swInvAll = 0;
  logic [47:0] reqVaddr = '0;
  logic [27:0] fillPpn = '0, swInsPpn = '0;
  logic [35:0] swInsVpn = '0, swInvVpn = '0;
  logic        reqReady, rspValid, missReq;
  logic [39:0] rspPaddr;
  logic [35:0] missVpn;
  logic [31:0] hitCount, missCount;

  rx_xlate_cache u_rx_xlate_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .missReq(missReq), .missVpn(missVpn), .fillValid(fillValid),
    .fillPpn(fillPpn), .swInsValid(swInsValid), .swInsVpn(swInsVpn),
    .swInsPpn(swInsPpn), .swInvOne(swInvOne), .swInvVpn(swInvVpn),
    .swInvAll(swInvAll), .hitCount(hitCount), .missCount(missCount)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mValid [16];
  logic [35:0] mVpn [16];
  logic [27:0] mPpn [16];
  int          mRr, mHits, mMisses;
  bit          mBusy, eRsp;
  logic [47:0] mHeld;
  logic [39:0] ePaddr;

  always @(posedge clk) begin
    int hit, tgt;
    bit busyOld, doIns;
    logic [35:0] iv;
    logic [27:0] ip;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mValid[i] = 0;
      mRr = 0; mHits = 0; mMisses = 0; mBusy = 0; eRsp = 0; mHeld = '0; ePaddr = '0;
    end else begin
      hit = -1;
      for (int i = 0; i < 16; i++)
        if (hit < 0 && mValid[i] && mVpn[i] == reqVaddr[47:12]) hit = i;
      busyOld = mBusy;
      eRsp = 0;
      doIns = 0; iv = '0; ip = '0;
      if (!busyOld && reqValid) begin
        if (hit >= 0) begin
          eRsp = 1; ePaddr = {mPpn[hit], reqVaddr[11:0]}; mHits++;
        end else begin
          mBusy = 1; mHeld = reqVaddr; mMisses++;
        end
      end
      if (busyOld && fillValid) begin
        eRsp = 1; ePaddr = {fillPpn, mHeld[11:0]}; mBusy = 0;
        doIns = 1; iv = mHeld[47:12]; ip = fillPpn;
      end else if (swInsValid) begin
        doIns = 1; iv = swInsVpn; ip = swInsPpn;
      end
      if (swInvAll) begin
        for (int i = 0; i < 16; i++) mValid[i] = 0;
      end else begin
        tgt = -1;
        for (int i = 0; i < 16; i++) if (tgt < 0 && mValid[i] && mVpn[i] == iv) tgt = i;
        if (tgt < 0) for (int i = 0; i < 16; i++) if (tgt < 0 && !mValid[i]) tgt = i;
        if (swInvOne)
          for (int i = 0; i < 16; i++) if (mValid[i] && mVpn[i] == swInvVpn) mValid[i] = 0;
        if (doIns) begin
          if (tgt < 0) begin tgt = mRr; mRr = (mRr + 1) % 16; end
          mValid[tgt] = 1; mVpn[tgt] = iv; mPpn[tgt] = ip;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R5 reqReady", 64'(reqReady), 64'(!mBusy));
      chk("R4 missReq", 64'(missReq), 64'(mBusy));
      if (mBusy) chk("R4 missVpn", 64'(missVpn), 64'(mHeld[47:12]));
      chk("R3 rspValid", 64'(rspValid), 64'(eRsp));
      if (eRsp) chk("R2 rspPaddr", 64'(rspPaddr), 64'(ePaddr));
      chk("R3 hitCount", 64'(hitCount), 64'(mHits));
      chk("R4 missCount", 64'(missCount), 64'(mMisses));
    end
  end

  function automatic logic [47:0] va(input logic [35:0] vpn, input logic [11:0] off);
    return {vpn, off};
  endfunction

  task automatic xlate(input logic [35:0] vpn, input logic [11:0] off, input logic [27:0] fp,
                       input bit expHit, input logic [27:0] expPpn, input string tag);
    @(negedge clk); reqValid = 1; reqVaddr = va(vpn, off);
    @(negedge clk); reqValid = 0;
    chk({tag, " miss flag"}, 64'(missReq), 64'(!expHit));
    if (expHit) begin
      chk({tag, " hit rsp"}, 64'(rspValid), 64'd1);
      chk({tag, " hit addr"}, 64'(rspPaddr), 64'({expPpn, off}));
    end else begin
      chk({tag, " miss vpn"}, 64'(missVpn), 64'(vpn));
      repeat (2) @(negedge clk);
      fillValid = 1; fillPpn = fp;
      @(negedge clk); fillValid = 0;
      chk({tag, " fill rsp"}, 64'(rspValid), 64'd1);
      chk({tag, " fill addr"}, 64'(rspPaddr), 64'({fp, off}));
    end
  endtask

  task automatic swIns(input logic [35:0] vpn, input logic [27:0] ppn);
    @(negedge clk); swInsValid = 1; swInsVpn = vpn; swInsPpn = ppn;
    @(negedge clk); swInsValid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 ready", 64'(reqReady), 64'd1);
    chk("R1 rsp", 64'(rspValid), 64'd0);
    chk("R1 missReq", 64'(missReq), 64'd0);
    chk("R1 hitCount", 64'(hitCount), 64'd0);
    chk("R1 missCount", 64'(missCount), 64'd0);

    // first lookup misses on an empty table, then hits
    xlate(36'h10000, 12'habc, 28'h123, 0, '0, "R1 R4 R5 cold");
    xlate(36'h10000, 12'h005, '0, 1, 28'h123, "R3 R2 reuse");
    chk("R4 missCount", 64'(missCount), 64'd1);
    chk("R3 hitCount", 64'(hitCount), 64'd1);

    // software insert and overwrite of the same page
    swIns(36'h200, 28'h456);
    xlate(36'h200, 12'hfff, '0, 1, 28'h456, "R7 insert");
    swIns(36'h200, 28'h789);
    xlate(36'h200, 12'h000, '0, 1, 28'h789, "R6 overwrite");

    // fill remaining 14 slots, then replacement by round robin
    for (int k = 0; k < 14; k++) swIns(36'h300 + 36'(k), 28'h500 + 28'(k));
    xlate(36'h400, 12'h010, 28'h999, 0, '0, "R6 full miss");
    xlate(36'h10000, 12'h020, 28'h111, 0, '0, "R6 slot0 evicted");
    xlate(36'h200, 12'h030, 28'h222, 0, '0, "R6 slot1 evicted");
    xlate(36'h301, 12'h040, '0, 1, 28'h501, "R6 survivor");
    xlate(36'h400, 12'h050, '0, 1, 28'h999, "R6 new entry");

    // single invalidate
    @(negedge clk); swInvOne = 1; swInvVpn = 36'h301;
    @(negedge clk); swInvOne = 0;
    xlate(36'h302, 12'h060, '0, 1, 28'h502, "R9 neighbour kept");
    xlate(36'h301, 12'h070, 28'h601, 0, '0, "R9 removed");

    // lookup in the same cycle as invalidating its page
    @(negedge clk); swInvOne = 1; swInvVpn = 36'h302; reqValid = 1; reqVaddr = va(36'h302, 12'h080);
    @(negedge clk); swInvOne = 0; reqValid = 0;
    chk("R10 old contents rsp", 64'(rspValid), 64'd1);
    chk("R10 old contents addr", 64'(rspPaddr), 64'({28'h502, 12'h080}));
    xlate(36'h302, 12'h090, 28'h602, 0, '0, "R10 R9 gone after");

    // software insert colliding with a refill is dropped
    @(negedge clk); reqValid = 1; reqVaddr = va(36'h700, 12'h0a0);
    @(negedge clk); reqValid = 0;
    @(negedge clk); fillValid = 1; fillPpn = 28'h777;
    swInsValid = 1; swInsVpn = 36'h701; swInsPpn = 28'h888;
    @(negedge clk); fillValid = 0; swInsValid = 0;
    chk("R7 refill wins rsp", 64'(rspPaddr), 64'({28'h777, 12'h0a0}));
    xlate(36'h700, 12'h0b0, '0, 1, 28'h777, "R7 refill installed");
    xlate(36'h701, 12'h0c0, 28'h888, 0, '0, "R7 insert dropped");

    // global invalidate
    @(negedge clk); swInvAll = 1;
    @(negedge clk); swInvAll = 0;
    xlate(36'h400, 12'h0d0, 28'h444, 0, '0, "R8 cleared 400");
    xlate(36'h700, 12'h0e0, 28'h555, 0, '0, "R8 cleared 700");
    xlate(36'h400, 12'h0f0, '0, 1, 28'h444, "R8 refill after clear");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule